// File: doc/BRIEF.md
# Two-Level Interrupt Status Aggregator

This block collects completion events from a network controller's receive path, transmit path and management-interface logic. It folds them into one level-sensitive interrupt request. Receive and transmit events set bits in a 32-bit main status register. Management events set bits in a separate 16-bit management status register. The unmasked part of the management register forms a summary bit. That summary appears at bit 23 of the main status view and raises the interrupt on its own.

Software reaches the four registers through a simple word-wide read/write port. A read returns the register value one cycle after the request. Reading a status register clears it: the main register is cleared except for the management summary, and the management register is cleared completely. Two extra word offsets act as aliases of the main status and main mask registers, so software that uses either set of offsets sees the same registers.

Top module: `irq_aggregator`

## Requirements
- R1: A pulse on `ev_rx_done`, `ev_tx_host` or `ev_tx_all` sets main status bit 16, 24 or 25 respectively. Each bit set in `ev_mgmt` sets the same bit of the management status register.
- R2: In the main mask (offset 0x104) and the management mask (offset 0x120), a 1 disables the matching status bit. The management mask holds 16 bits, and bits 31:16 read back as 0.
- R3: Bit 23 of the main status read value is 1 exactly when the management status has a bit whose mask bit is 0. It raises the interrupt whatever main mask bit 23 holds.
- R4: `irq_o` is registered. It is 1 in the cycle after any main status bit (other than 23) whose main mask bit is 0 is set, or after the management summary is 1. Otherwise it is 0.
- R5: Reading main status (offset 0x100) returns the current value and then clears every bit. Bit 23 remains, because it still reflects the management status.
- R6: Reading management status (offset 0x124) returns its value in bits 15:0 and then clears all 16 bits.
- R7: Offset 0x108 aliases main status, and offset 0x10C aliases main mask, for both reads and writes.
- R8: After reset, the main mask is 0xFF7FFFFF, the management mask is 0x0000FFFF, both status registers are 0, and `irq_o` is 0.
- R9: When an event sets a status bit in the same cycle as a clearing read of that register, the bit is 1 after the read.
- R10: A read request gives `bus_rvalid` = 1 and the data on `bus_rdata` in the next cycle. With no read, both are 0.
- R11: Address bits 1:0 are ignored. Reads of any other offset return 0, and writes to them change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_valid | input | 1 | Register access request |
| bus_write | input | 1 | 1 = write, 0 = read |
| bus_addr | input | ADDR_W | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data, one cycle after the request |
| bus_rvalid | output | 1 | Read data valid |
| ev_rx_done | input | 1 | Receive-to-host event pulse |
| ev_tx_host | input | 1 | Host-to-transmit done event pulse |
| ev_tx_all | input | 1 | Transmit-all-done event pulse |
| ev_mgmt | input | 16 | Management interface event bits |
| irq_o | output | 1 | Level interrupt request |

## Verification
The directed patterns cover several cases:
- A single event under the default masks, which shows that masking is separate from status capture.
- Events after unmasking, which expose the one-cycle interrupt latency.
- A management event with the main mask set to all ones, which separates the derived summary from a stored bit.
- Back-to-back reads, which show that only the summary survives a clear.

Alias, collision and unmapped-offset cases each pair a write or event with a read through the other offset or in the same cycle. A long stretch of random traffic then mixes every offset, including unmapped ones, with random events, so that clears, writes and events overlap in every order.

// File: rtl/irq_agg_pkg.sv
package irq_agg_pkg;

    localparam int DATA_W = 32;
    localparam int MGMT_W = 16;

    localparam int BIT_RX   = 16;
    localparam int BIT_MGMT = 23;
    localparam int BIT_TXH  = 24;
    localparam int BIT_TXA  = 25;

    localparam logic [DATA_W-1:0] MAIN_MASK_RST = 32'hFF7F_FFFF;
    localparam logic [MGMT_W-1:0] MGMT_MASK_RST = 16'hFFFF;

    // Bits of the main status that are held in flops (summary is derived)
    localparam logic [DATA_W-1:0] MAIN_STORE_MASK = ~(DATA_W'(1) << BIT_MGMT);

    typedef enum logic [2:0] {
        SEL_NONE,
        SEL_MAIN_STAT,
        SEL_MAIN_MASK,
        SEL_MGMT_STAT,
        SEL_MGMT_MASK
    } reg_sel_e;

    localparam int NUM_MAP = 6;
    localparam logic [15:0] MAP_OFFS [NUM_MAP] =
        '{16'h0100, 16'h0104, 16'h0108, 16'h010C, 16'h0120, 16'h0124};
    localparam reg_sel_e MAP_SEL [NUM_MAP] =
        '{SEL_MAIN_STAT, SEL_MAIN_MASK, SEL_MAIN_STAT, SEL_MAIN_MASK,
          SEL_MGMT_MASK, SEL_MGMT_STAT};

    typedef struct packed {
        logic              rd;
        logic              wr;
        reg_sel_e          sel;
        logic [DATA_W-1:0] wdata;
    } reg_access_t;

    typedef struct packed {
        logic rx_done;
        logic tx_host;
        logic tx_all;
    } main_event_t;

    function automatic logic [DATA_W-1:0] main_event_bits(main_event_t e);
        logic [DATA_W-1:0] v;
        v          = '0;
        v[BIT_RX]  = e.rx_done;
        v[BIT_TXH] = e.tx_host;
        v[BIT_TXA] = e.tx_all;
        return v;
    endfunction

endpackage

// File: rtl/irq_addr_decode.sv
module irq_addr_decode
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic [ADDR_W-1:0] addr,
    output reg_sel_e          sel
);
    localparam logic [ADDR_W-1:0] WORD_MASK = ~ADDR_W'(3);

    logic [NUM_MAP-1:0] hit;

    generate
        for (genvar g = 0; g < NUM_MAP; g++) begin : g_map
            localparam logic [ADDR_W-1:0] OFF_G = ADDR_W'(MAP_OFFS[g]);
            assign hit[g] = ((addr ^ OFF_G) & WORD_MASK) == '0;
        end
    endgenerate

    always_comb begin
        sel = SEL_NONE;
        for (int i = 0; i < NUM_MAP; i++) begin
            if (hit[i]) sel = MAP_SEL[i];
        end
    end
endmodule

// File: rtl/irq_main_status.sv
module irq_main_status
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  reg_access_t       acc,
    input  main_event_t       ev,
    output logic [DATA_W-1:0] stat_q
);
    logic [DATA_W-1:0] stat_d;

    always_comb begin
        stat_d = stat_q;
        if (acc.wr && acc.sel == SEL_MAIN_STAT) begin
            stat_d = acc.wdata;
        end else if (acc.rd && acc.sel == SEL_MAIN_STAT) begin
            stat_d = '0;
        end
        // events applied last so they win over a clearing read
        stat_d = (stat_d | main_event_bits(ev)) & MAIN_STORE_MASK;
    end

    always_ff @(posedge clk) begin
        if (rst) stat_q <= '0;
        else     stat_q <= stat_d;
    end
endmodule

// File: rtl/irq_mgmt_status.sv
module irq_mgmt_status
    import irq_agg_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              rd_stat,
    input  logic              wr_stat,
    input  logic              wr_mask,
    input  logic [MGMT_W-1:0] wdata,
    input  logic [MGMT_W-1:0] ev_bits,
    output logic [MGMT_W-1:0] stat_q,
    output logic [MGMT_W-1:0] mask_q,
    output logic              summary
);
    logic [MGMT_W-1:0] stat_d;

    always_comb begin
        stat_d = stat_q;
        if (wr_stat)      stat_d = wdata;
        else if (rd_stat) stat_d = '0;
        stat_d = stat_d | ev_bits;
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            stat_q <= '0;
            mask_q <= MGMT_MASK_RST;
        end else begin
            stat_q <= stat_d;
            if (wr_mask) mask_q <= wdata;
        end
    end

    assign summary = |(stat_q & ~mask_q);
endmodule

// File: rtl/irq_aggregator.sv
module irq_aggregator
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_valid,
    input  logic              bus_write,
    input  logic [ADDR_W-1:0] bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    output logic              bus_rvalid,
    input  logic              ev_rx_done,
    input  logic              ev_tx_host,
    input  logic              ev_tx_all,
    input  logic [MGMT_W-1:0] ev_mgmt,
    output logic              irq_o
);
    reg_sel_e          sel;
    reg_access_t       acc;
    main_event_t       mev;
    logic [DATA_W-1:0] main_stat_q;
    logic [DATA_W-1:0] main_mask_q;
    logic [MGMT_W-1:0] mgmt_stat_q;
    logic [MGMT_W-1:0] mgmt_mask_q;
    logic              mgmt_summary;
    logic [DATA_W-1:0] main_view;
    logic [DATA_W-1:0] rd_value;
    logic              irq_d;

    irq_addr_decode #(.ADDR_W(ADDR_W)) u_dec (
        .addr (bus_addr),
        .sel  (sel)
    );

    always_comb begin
        acc.rd    = bus_valid & ~bus_write;
        acc.wr    = bus_valid & bus_write;
        acc.sel   = sel;
        acc.wdata = bus_wdata;
        mev.rx_done = ev_rx_done;
        mev.tx_host = ev_tx_host;
        mev.tx_all  = ev_tx_all;
    end

    irq_main_status u_main (
        .clk    (clk),
        .rst    (rst),
        .acc    (acc),
        .ev     (mev),
        .stat_q (main_stat_q)
    );

    irq_mgmt_status u_mgmt (
        .clk     (clk),
        .rst     (rst),
        .rd_stat (acc.rd && sel == SEL_MGMT_STAT),
        .wr_stat (acc.wr && sel == SEL_MGMT_STAT),
        .wr_mask (acc.wr && sel == SEL_MGMT_MASK),
        .wdata   (bus_wdata[MGMT_W-1:0]),
        .ev_bits (ev_mgmt),
        .stat_q  (mgmt_stat_q),
        .mask_q  (mgmt_mask_q),
        .summary (mgmt_summary)
    );

    always_ff @(posedge clk) begin
        if (rst)                               main_mask_q <= MAIN_MASK_RST;
        else if (acc.wr && sel == SEL_MAIN_MASK) main_mask_q <= bus_wdata;
    end

    assign main_view = main_stat_q | (DATA_W'(mgmt_summary) << BIT_MGMT);

    always_comb begin
        unique case (sel)
            SEL_MAIN_STAT: rd_value = main_view;
            SEL_MAIN_MASK: rd_value = main_mask_q;
            SEL_MGMT_STAT: rd_value = DATA_W'(mgmt_stat_q);
            SEL_MGMT_MASK: rd_value = DATA_W'(mgmt_mask_q);
            default:       rd_value = '0;
        endcase
    end

    // main mask bit of the summary position takes no part
    assign irq_d = (|(main_stat_q & ~main_mask_q & MAIN_STORE_MASK)) | mgmt_summary;

    always_ff @(posedge clk) begin
        if (rst) begin
            bus_rdata  <= '0;
            bus_rvalid <= 1'b0;
            irq_o      <= 1'b0;
        end else begin
            bus_rdata  <= acc.rd ? rd_value : '0;
            bus_rvalid <= acc.rd;
            irq_o      <= irq_d;
        end
    end
endmodule

// File: rtl/irq_aggregator_chk.sv
module irq_aggregator_chk
    import irq_agg_pkg::*;
#(
    parameter int ADDR_W = 12
) (
    input logic              clk,
    input logic              rst,
    input logic              bus_valid,
    input logic              bus_write,
    input logic [ADDR_W-1:0] bus_addr,
    input logic [DATA_W-1:0] bus_wdata,
    input logic              bus_rvalid,
    input logic              ev_rx_done,
    input logic              ev_tx_host,
    input logic              ev_tx_all,
    input logic [MGMT_W-1:0] ev_mgmt,
    input logic              irq_o,
    input reg_sel_e          sel,
    input logic [DATA_W-1:0] main_stat_q,
    input logic [DATA_W-1:0] main_mask_q,
    input logic [MGMT_W-1:0] mgmt_stat_q,
    input logic [MGMT_W-1:0] mgmt_mask_q
);
    localparam logic [ADDR_W-1:0] ALIAS_MASK_OFF = ADDR_W'(16'h010C);

    logic any_main_ev;
    logic main_live;
    logic mgmt_live;
    logic alias_mask_wr;

    assign any_main_ev   = ev_rx_done | ev_tx_host | ev_tx_all;
    assign main_live     = |(main_stat_q & ~main_mask_q & MAIN_STORE_MASK);
    assign mgmt_live     = |(mgmt_stat_q & ~mgmt_mask_q);
    assign alias_mask_wr = bus_valid && bus_write &&
                           (((bus_addr ^ ALIAS_MASK_OFF) & ~ADDR_W'(3)) == '0);

    AST_RX_EVENT_SETS: assert property (@(posedge clk) disable iff (rst)
        ev_rx_done |=> main_stat_q[BIT_RX]); // R1

    AST_TXALL_BEATS_CLEAR: assert property (@(posedge clk) disable iff (rst)
        (ev_tx_all && bus_valid && !bus_write && sel == SEL_MAIN_STAT)
        |=> main_stat_q[BIT_TXA]); // R9

    AST_MGMT_RAISES_IRQ: assert property (@(posedge clk) disable iff (rst)
        mgmt_live |=> irq_o); // R3

    AST_IRQ_QUIET: assert property (@(posedge clk) disable iff (rst)
        (!main_live && !mgmt_live) |=> !irq_o); // R4

    AST_MAIN_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && sel == SEL_MAIN_STAT && !any_main_ev)
        |=> main_stat_q == '0); // R5

    AST_MGMT_READ_CLEARS: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write && sel == SEL_MGMT_STAT && ev_mgmt == '0)
        |=> mgmt_stat_q == '0); // R6

    AST_ALIAS_MASK_WRITE: assert property (@(posedge clk) disable iff (rst)
        alias_mask_wr |=> main_mask_q == $past(bus_wdata)); // R7

    AST_RESET_MASKS: assert property (@(posedge clk) disable iff (rst)
        $fell(rst) |-> (main_mask_q == MAIN_MASK_RST &&
                        mgmt_mask_q == MGMT_MASK_RST)); // R8

    AST_READ_VALID: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && !bus_write) |=> bus_rvalid); // R10

    AST_UNMAPPED_WRITE: assert property (@(posedge clk) disable iff (rst)
        (bus_valid && bus_write && sel == SEL_NONE)
        |=> ($stable(main_mask_q) && $stable(mgmt_mask_q))); // R11
endmodule

bind irq_aggregator irq_aggregator_chk #(.ADDR_W(ADDR_W)) u_chk (
    .clk         (clk),
    .rst         (rst),
    .bus_valid   (bus_valid),
    .bus_write   (bus_write),
    .bus_addr    (bus_addr),
    .bus_wdata   (bus_wdata),
    .bus_rvalid  (bus_rvalid),
    .ev_rx_done  (ev_rx_done),
    .ev_tx_host  (ev_tx_host),
    .ev_tx_all   (ev_tx_all),
    .ev_mgmt     (ev_mgmt),
    .irq_o       (irq_o),
    .sel         (sel),
    .main_stat_q (main_stat_q),
    .main_mask_q (main_mask_q),
    .mgmt_stat_q (mgmt_stat_q),
    .mgmt_mask_q (mgmt_mask_q)
);

// File: tb/tb_irq_aggregator.sv
`timescale 1ns/1ps
module tb_irq_aggregator;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_valid = 1'b0;
    logic        bus_write = 1'b0;
    logic [11:0] bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        bus_rvalid;
    logic        ev_rx_done = 1'b0;
    logic        ev_tx_host = 1'b0;
    logic        ev_tx_all = 1'b0;
    logic [15:0] ev_mgmt = '0;
    logic        irq_o;

    always #10 clk = ~clk;

    irq_aggregator #(.ADDR_W(12)) dut (
        .clk(clk), .rst(rst),
        .bus_valid(bus_valid), .bus_write(bus_write),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata),
        .bus_rdata(bus_rdata), .bus_rvalid(bus_rvalid),
        .ev_rx_done(ev_rx_done), .ev_tx_host(ev_tx_host),
        .ev_tx_all(ev_tx_all), .ev_mgmt(ev_mgmt), .irq_o(irq_o)
    );

    // reference state
    logic [31:0] m_main, m_mmask, m_rdata;
    logic [15:0] m_gstat, m_gmask;
    logic        m_irq, m_rdv;
    int          vectors = 0;
    int          fails = 0;
    bit          done = 0;
    string       cur_req = "R8";

    // 0 none, 1 main stat, 2 main mask, 3 mgmt stat, 4 mgmt mask
    function automatic int which_reg(logic [11:0] a);
        case ({a[11:2], 2'b00})
            12'h100, 12'h108: return 1;
            12'h104, 12'h10C: return 2;
            12'h124:          return 3;
            12'h120:          return 4;
            default:          return 0;
        endcase
    endfunction

    task automatic model_step();
        logic        summ;
        logic [31:0] view, rv;
        int          r;
        if (rst) begin
            m_main = 0; m_mmask = 32'hFF7FFFFF; m_gstat = 0; m_gmask = 16'hFFFF;
            m_irq = 0; m_rdv = 0; m_rdata = 0;
            return;
        end
        summ = (m_gstat & ~m_gmask) != 0;
        view = m_main | (summ ? 32'h0080_0000 : 32'h0);
        r = which_reg(bus_addr);
        case (r)
            1: rv = view;
            2: rv = m_mmask;
            3: rv = {16'h0, m_gstat};
            4: rv = {16'h0, m_gmask};
            default: rv = 0;
        endcase
        m_irq   = ((m_main & ~m_mmask & ~32'h0080_0000) != 0) || summ;
        m_rdv   = bus_valid && !bus_write;
        m_rdata = m_rdv ? rv : 32'h0;
        if (bus_valid) begin
            if (bus_write) begin
                if (r == 1) m_main = bus_wdata;
                if (r == 2) m_mmask = bus_wdata;
                if (r == 3) m_gstat = bus_wdata[15:0];
                if (r == 4) m_gmask = bus_wdata[15:0];
            end else begin
                if (r == 1) m_main = 0;
                if (r == 3) m_gstat = 0;
            end
        end
        if (ev_rx_done) m_main[16] = 1'b1;
        if (ev_tx_host) m_main[24] = 1'b1;
        if (ev_tx_all)  m_main[25] = 1'b1;
        m_main[23] = 1'b0;
        m_gstat = m_gstat | ev_mgmt;
    endtask

    task automatic compare();
        vectors++;
        if (irq_o !== m_irq || bus_rvalid !== m_rdv || bus_rdata !== m_rdata) begin
            fails++;
            $display("FAIL %s: irq/rvalid/rdata actual %b/%b/%h expected %b/%b/%h",
                     cur_req, irq_o, bus_rvalid, bus_rdata, m_irq, m_rdv, m_rdata);
        end
    endtask

    task automatic tick();
        @(posedge clk);
        model_step();
        @(negedge clk);
        compare();
    endtask

    task automatic chk(string tag, logic [31:0] act, logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            fails++;
            $display("FAIL %s: actual %h expected %h", tag, act, exp);
        end
    endtask

    task automatic rd(logic [11:0] a, logic [31:0] exp, string tag);
        cur_req = tag;
        bus_valid = 1; bus_write = 0; bus_addr = a;
        tick();
        bus_valid = 0;
        chk(tag, bus_rdata, exp);
    endtask

    task automatic wr(logic [11:0] a, logic [31:0] d);
        bus_valid = 1; bus_write = 1; bus_addr = a; bus_wdata = d;
        tick();
        bus_valid = 0; bus_write = 0;
    endtask

    task automatic idle(int n);
        for (int i = 0; i < n; i++) tick();
    endtask

    initial begin
        #(20 * 150000);
        if (!done) begin
            fails++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
            $finish;
        end
    end

    initial begin
        @(negedge clk);
        idle(3);
        rst = 0;
        idle(1);
        // R8 reset state
        chk("R8", {31'h0, irq_o}, 32'h0);
        rd(12'h104, 32'hFF7FFFFF, "R8");
        rd(12'h120, 32'h0000FFFF, "R8");
        rd(12'h100, 32'h0, "R8");

        // R1 event capture, R2 default mask blocks it
        ev_rx_done = 1; tick(); ev_rx_done = 0;
        idle(2);
        chk("R2", {31'h0, irq_o}, 32'h0);
        rd(12'h100, 32'h0001_0000, "R1");

        // R4 registered interrupt latency
        wr(12'h104, 32'hFEFEFFFF);
        ev_tx_host = 1; tick(); ev_tx_host = 0;
        chk("R4", {31'h0, irq_o}, 32'h0);
        ev_rx_done = 1; tick(); ev_rx_done = 0;
        chk("R4", {31'h0, irq_o}, 32'h1);
        rd(12'h100, 32'h0101_0000, "R1");
        tick();
        chk("R5", {31'h0, irq_o}, 32'h0);

        // R3 management summary
        ev_mgmt = 16'h0004; tick(); ev_mgmt = 0;
        idle(1);
        chk("R2", {31'h0, irq_o}, 32'h0);
        rd(12'h100, 32'h0, "R3");
        wr(12'h120, 32'h0000FFFB);
        wr(12'h104, 32'hFFFFFFFF);
        idle(1);
        chk("R3", {31'h0, irq_o}, 32'h1);
        rd(12'h100, 32'h0080_0000, "R3");
        rd(12'h100, 32'h0080_0000, "R5");
        rd(12'h124, 32'h0000_0004, "R6");
        idle(1);
        chk("R6", {31'h0, irq_o}, 32'h0);
        rd(12'h124, 32'h0, "R6");

        // R7 aliases
        wr(12'h10C, 32'h0);
        rd(12'h104, 32'h0, "R7");
        wr(12'h104, 32'h12345678);
        rd(12'h10C, 32'h12345678, "R7");
        ev_tx_all = 1; tick(); ev_tx_all = 0;
        rd(12'h108, 32'h0200_0000, "R7");
        rd(12'h100, 32'h0, "R5");

        // R9 event against clearing read
        ev_rx_done = 1; tick();
        cur_req = "R9";
        bus_valid = 1; bus_write = 0; bus_addr = 12'h100;
        tick();
        bus_valid = 0; ev_rx_done = 0;
        chk("R9", bus_rdata, 32'h0001_0000);
        rd(12'h100, 32'h0001_0000, "R9");
        rd(12'h100, 32'h0, "R9");
        wr(12'h120, 32'h0000FFFF);
        ev_mgmt = 16'h0010; tick();
        ev_mgmt = 16'h0001;
        bus_valid = 1; bus_write = 0; bus_addr = 12'h124;
        tick();
        bus_valid = 0; ev_mgmt = 0;
        chk("R9", bus_rdata, 32'h0000_0010);
        rd(12'h124, 32'h0000_0001, "R9");

        // R2 mask width, R11 unmapped and low address bits
        wr(12'h120, 32'hFFFF0000);
        rd(12'h120, 32'h0, "R2");
        wr(12'h1F0, 32'hAAAAAAAA);
        rd(12'h104, 32'h12345678, "R11");
        rd(12'h120, 32'h0, "R11");
        rd(12'h1F0, 32'h0, "R11");
        rd(12'h105, 32'h12345678, "R11");
        rd(12'h126, 32'h0, "R11");

        // mixed random traffic against the reference model (R10 valid timing)
        cur_req = "R10";
        for (int i = 0; i < 3000; i++) begin
            logic [11:0] addrs [8];
            addrs = '{12'h100, 12'h104, 12'h108, 12'h10C,
                      12'h120, 12'h124, 12'h1F0, 12'h102};
            bus_valid  = ($urandom % 3) != 0;
            bus_write  = ($urandom % 3) == 0;
            bus_addr   = addrs[$urandom % 8];
            bus_wdata  = $urandom;
            ev_rx_done = ($urandom % 5) == 0;
            ev_tx_host = ($urandom % 7) == 0;
            ev_tx_all  = ($urandom % 9) == 0;
            ev_mgmt    = (($urandom % 6) == 0) ? 16'($urandom) : 16'h0;
            tick();
        end
        bus_valid = 0; ev_rx_done = 0; ev_tx_host = 0; ev_tx_all = 0; ev_mgmt = 0;
        idle(2);

        done = 1;
        $display("== %0d vectors applied, %0d miscompares ==", vectors, fails);
        $finish;
    end
endmodule